// File: doc/BRIEF.md
# Ternary Digit-Sum Divisibility Recognizer

This block is a clocked recognizer that reads a string of base-3 digits, one digit per clock cycle, and reports whether the sum of all digits read so far is a multiple of three. Each digit arrives as a 2-bit code with a valid strobe. Codes 0, 1 and 2 carry the digit values. Code 3 is reserved. The block keeps one of three residue states for the running sum. Its registered accept flag is high exactly when that residue is zero.

A clear input starts a new string without a full reset. The empty string counts as accepted, so accept is high right after reset or clear. A reserved digit code does not change the residue. Instead it raises a sticky error flag, which stays high until the next clear or reset.

The digit width and the modulus are parameters. With the default values, the reserved codes are exactly the code values at or above the modulus.

Top module: `tsum_mod3_rec`

## Requirements
- R1: In the cycle after synchronous reset `rst` has been high at a clock edge, `accept` is 1 and `digitErr` is 0.
- R2: On a clock edge with `digitValid` high, `clear` low and `digit` equal to 0, 1 or 2, the digit value is added to the running sum modulo 3. `accept` is 1 exactly when the running sum since the last clear or reset is congruent to 0 mod 3.
- R3: A valid digit with code 0 leaves `accept` unchanged.
- R4: On an edge with `digitValid` low and `clear` low, `accept` and `digitErr` keep their values, and the residue does not change.
- R5: A valid digit with the reserved code 3 (2'b11) leaves the residue and `accept` unchanged and sets `digitErr` in the next cycle.
- R6: Once set, `digitErr` stays high until `clear` or `rst` is high at a clock edge. Legal digits in the meantime do not clear it.
- R7: `clear` high at an edge sets the residue to 0, `accept` to 1 and `digitErr` to 0. A digit presented in the same cycle as `clear` is ignored.
- R8: `accept` is a register output. It changes in the cycle after the edge that consumed the digit, together with the residue state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Start a new string; clears the residue and the error flag |
| digitValid | input | 1 | Qualifies `digit` in this cycle |
| digit | input | 2 | Digit code: 0, 1 or 2 for the digit value; 3 is reserved |
| accept | output | 1 | Running digit sum is divisible by three |
| digitErr | output | 1 | Sticky flag: a reserved code was seen |

## Verification
The bench builds the block with its default parameters: a 2-bit digit code and modulus 3. With these values, exactly one reserved code exists, so all four code values can be driven and the error path is exercised directly. A pseudo-random stream of several hundred digits is mixed with idle cycles, reserved codes and clears. This steers the residue through every transition between the three states. It also hits the case where a clear arrives together with a valid digit.

// File: rtl/tsum_mod3_pkg.sv
package tsum_mod3_pkg;
  // Strobes from control to datapath, one-hot or all zero per cycle
  typedef struct packed {
    logic restart;   // return to residue zero, drop the error flag
    logic advance;   // fold the legal digit into the residue
    logic flagErr;   // reserved code seen
  } ctrlStrobe_t;
endpackage

// File: rtl/tsum_mod3_ctrl.sv
module tsum_mod3_ctrl
  import tsum_mod3_pkg::*;
#(
  parameter int DIGIT_W = 2,
  parameter int MODULUS = 3
) (
  input  logic               rst,
  input  logic               clear,
  input  logic               digitValid,
  input  logic [DIGIT_W-1:0] digit,
  output ctrlStrobe_t        strobe
);
  localparam logic [31:0] MOD_U = MODULUS;

  logic digitLegal;
  assign digitLegal = (32'(digit) < MOD_U);

  always_comb begin
    strobe = '0;
    if (rst || clear) begin
      strobe.restart = 1'b1;
    end else if (digitValid) begin
      if (digitLegal) strobe.advance = 1'b1;
      else            strobe.flagErr = 1'b1;
    end
  end
endmodule

// File: rtl/tsum_mod3_dp.sv
module tsum_mod3_dp
  import tsum_mod3_pkg::*;
#(
  parameter int DIGIT_W = 2,
  parameter int MODULUS = 3
) (
  input  logic               clk,
  input  ctrlStrobe_t        strobe,
  input  logic [DIGIT_W-1:0] digit,
  output logic               accept,
  output logic               digitErr
);
  localparam int RES_W = (MODULUS > 2) ? $clog2(MODULUS) : 1;
  localparam int SUM_W = ((RES_W > DIGIT_W) ? RES_W : DIGIT_W) + 1;
  localparam logic [SUM_W-1:0] MOD_S = SUM_W'(MODULUS);

  logic [RES_W-1:0] residue;
  logic [RES_W-1:0] nextRes;
  logic [SUM_W-1:0] sumWide;

  // Digit is below the modulus when advance is set, so one subtraction wraps
  always_comb begin
    sumWide = SUM_W'(residue) + SUM_W'(digit);
    if (sumWide >= MOD_S) nextRes = RES_W'(sumWide - MOD_S);
    else                  nextRes = RES_W'(sumWide);
  end

  always_ff @(posedge clk) begin
    if (strobe.restart) begin
      residue  <= '0;
      accept   <= 1'b1;
      digitErr <= 1'b0;
    end else begin
      if (strobe.advance) begin
        residue <= nextRes;
        accept  <= (nextRes == '0);
      end
      if (strobe.flagErr) digitErr <= 1'b1;
    end
  end
endmodule

// File: rtl/tsum_mod3_rec.sv
module tsum_mod3_rec
  import tsum_mod3_pkg::*;
#(
  parameter int DIGIT_W = 2,
  parameter int MODULUS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               digitValid,
  input  logic [DIGIT_W-1:0] digit,
  output logic               accept,
  output logic               digitErr
);
  ctrlStrobe_t strobe;

  tsum_mod3_ctrl #(.DIGIT_W(DIGIT_W), .MODULUS(MODULUS)) u_ctrl (
    .rst        (rst),
    .clear      (clear),
    .digitValid (digitValid),
    .digit      (digit),
    .strobe     (strobe)
  );

  tsum_mod3_dp #(.DIGIT_W(DIGIT_W), .MODULUS(MODULUS)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .digit    (digit),
    .accept   (accept),
    .digitErr (digitErr)
  );
endmodule

// File: rtl/tsum_mod3_chk.sv
module tsum_mod3_chk #(
  parameter int DIGIT_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               clear,
  input logic               digitValid,
  input logic [DIGIT_W-1:0] digit,
  input logic               accept,
  input logic               digitErr
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (accept && !digitErr)); // R1

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clear && digitValid && digit == '0) |=> $stable(accept)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clear && !digitValid) |=> ($stable(accept) && $stable(digitErr))); // R4

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    (!clear && digitValid && digit == '1) |=> (digitErr && $stable(accept))); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (digitErr && !clear) |=> digitErr); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear |=> (accept && !digitErr)); // R7
endmodule

bind tsum_mod3_rec tsum_mod3_chk #(.DIGIT_W(DIGIT_W)) u_chk (.*);

// File: tb/tsum_mod3_rec_test.sv
`timescale 1ns/1ps
module tsum_mod3_rec_test;
  typedef struct {
    logic  expAcc;
    logic  expErr;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic digitValid = 1'b0;
  logic [1:0] digit = 2'd0;
  logic accept;
  logic digitErr;

  item_t expQ[$];
  int vectors = 0;
  int miscompares = 0;
  int modelSum = 0;
  logic modelErr = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsum_mod3_rec uut (
    .clk(clk), .rst(rst), .clear(clear), .digitValid(digitValid),
    .digit(digit), .accept(accept), .digitErr(digitErr)
  );

  task automatic stepCycle(input logic r, input logic c, input logic v,
                           input logic [1:0] d, input string req);
    item_t it;
    @(negedge clk);
    rst = r; clear = c; digitValid = v; digit = d;
    if (r || c) begin
      modelSum = 0; modelErr = 1'b0;
    end else if (v) begin
      if (d == 2'd3) modelErr = 1'b1;
      else modelSum = (modelSum + int'(d)) % 3;
    end
    it.expAcc = (modelSum == 0);
    it.expErr = modelErr;
    it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: one expected item per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        vectors++;
        if (accept !== it.expAcc || digitErr !== it.expErr) begin
          miscompares++;
          $display("FAIL %s: accept=%b digitErr=%b expected accept=%b digitErr=%b",
                   it.req, accept, digitErr, it.expAcc, it.expErr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: accept=%b expected run to finish", accept);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    // R1 reset state
    stepCycle(1, 0, 0, 0, "R1");
    stepCycle(1, 0, 1, 1, "R1");
    // R2 and R8: 1 then 2 completes a multiple of three
    stepCycle(0, 0, 1, 1, "R8");
    stepCycle(0, 0, 1, 2, "R2");
    stepCycle(0, 0, 1, 1, "R2");
    stepCycle(0, 0, 1, 1, "R2");
    stepCycle(0, 0, 1, 1, "R2");
    // R3 zero digits hold the flag
    stepCycle(0, 0, 1, 2, "R2");
    stepCycle(0, 0, 1, 0, "R3");
    stepCycle(0, 0, 1, 0, "R3");
    // R4 idle cycles with a nonzero digit on the bus
    stepCycle(0, 0, 0, 1, "R4");
    stepCycle(0, 0, 0, 2, "R4");
    // R5 reserved code with a nonzero residue
    stepCycle(0, 0, 1, 3, "R5");
    stepCycle(0, 0, 0, 0, "R4");
    // R6 legal digits do not drop the error
    stepCycle(0, 0, 1, 1, "R6");
    stepCycle(0, 0, 1, 2, "R6");
    stepCycle(0, 0, 1, 3, "R6");
    // R7 clear beats a valid digit in the same cycle
    stepCycle(0, 1, 1, 2, "R7");
    stepCycle(0, 0, 1, 2, "R2");
    stepCycle(0, 1, 1, 3, "R7");
    stepCycle(0, 0, 1, 2, "R2");
    stepCycle(0, 0, 1, 2, "R2");
    stepCycle(0, 0, 1, 2, "R2");
    // R1 reset mid-string clears error and residue
    stepCycle(0, 0, 1, 3, "R5");
    stepCycle(1, 0, 0, 0, "R1");
    // Mixed pseudo-random stream
    lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      logic fb;
      fb = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
      lfsr = {lfsr[6:0], fb};
      if (lfsr[7:3] == 5'd0)      stepCycle(0, 1, lfsr[0], lfsr[2:1], "R7");
      else if (lfsr[7:5] == 3'd7) stepCycle(0, 0, 0, lfsr[2:1], "R4");
      else if (lfsr[2:1] == 2'd3) stepCycle(0, 0, 1, 2'd3, "R6");
      else                        stepCycle(0, 0, 1, lfsr[2:1], "R2");
    end
    stepCycle(0, 0, 0, 0, "R4");
    @(negedge clk);
    wait (expQ.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule